// File: doc/BRIEF.md
# Content-defined chunk boundary detector

This block cuts a byte stream into variable-length chunks whose edges depend on the content and not on fixed offsets. It accepts one byte per cycle over a valid/ready handshake and keeps a rolling fingerprint of the 48 most recent bytes. The fingerprint is the remainder of that window, read as a polynomial over GF(2), after division by a fixed degree-64 generator. When the low 13 bits of the remainder equal a programmed marker, the current byte becomes the last byte of a chunk.

Two length bounds shape the result. A minimum length stops a marker match from closing a chunk that is too short, so the bytes right after a cut are never tested. A maximum length forces a cut when no marker has appeared. A bound of zero in both fields gives plain marker-driven cutting. Each cut is reported as one transfer on a valid/ready boundary port, carrying the stream offset of the chunk's last byte and the chunk length. An end-of-stream flag on an input byte closes the final partial chunk and restarts the stream state.

The fingerprint advances with two 256-entry lookups per byte. One folds back the byte that shifts past bit 63. The other cancels the byte that leaves the window.

Top module: `chunk_cutter`

## Requirements
- R1: The fingerprint after each accepted byte equals the remainder, modulo x^64 + POLY_LOW (default POLY_LOW = 0x1B), of the polynomial whose coefficients are the bits of the last 48 accepted bytes of the current stream. Bytes are taken oldest first and each byte MSB first, so the newest byte's bit 0 is the x^0 term. Positions before the stream start count as zero bytes. A marker match means fingerprint bits [12:0] equal cfg_marker.
- R2: Each boundary is one transfer on the boundary port with bnd_offset equal to the zero-based offset, within the current stream, of the chunk's last byte, and with bnd_len equal to the number of bytes in the chunk. The number and order of boundaries match the cut rules exactly.
- R3: No marker match produces a boundary until 48 bytes have been accepted since reset or since the last stream restart.
- R4: A marker match closes a chunk only when the chunk length including the current byte is greater than cfg_min_len.
- R5: When cfg_max_len is nonzero, a chunk is cut when its length reaches cfg_max_len, with or without a marker match. The bytes skipped under the minimum count toward this length. A cfg_max_len of 0 means no maximum.
- R6: With cfg_min_len = 0 and cfg_max_len = 0, a boundary occurs at exactly the bytes whose full-window fingerprint matches the marker, plus the end-of-stream byte.
- R7: A byte accepted with in_last = 1 always ends a chunk. The next accepted byte has offset 0, an empty window and a chunk length of 1.
- R8: While bnd_valid = 1 and bnd_ready = 0, in_ready is 0 and bnd_valid, bnd_offset and bnd_len hold their values.
- R9: During and right after reset, bnd_valid is 0 and in_ready is 1.
- R10: The test moves forward one byte per accepted byte, so boundaries can fall on consecutive bytes with length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_marker | input | MARK_W | Marker compared with the low fingerprint bits |
| cfg_min_len | input | LEN_W | Minimum chunk length for a marker cut |
| cfg_max_len | input | LEN_W | Forced-cut length, 0 means unlimited |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a stream |
| bnd_valid | output | 1 | Boundary record valid |
| bnd_ready | input | 1 | Boundary record taken when high together with bnd_valid |
| bnd_offset | output | OFF_W | Stream offset of the chunk's last byte |
| bnd_len | output | LEN_W | Chunk length in bytes |

## Verification
A behavioural model in the bench recomputes every window remainder by long division over 384 bits. It predicts every cut, so a wrong or wrongly aligned outgoing-byte correction shows up as boundaries missing or misplaced after byte 48. An all-zero stream with marker 0 checks the window fill: a design that ignores the fill count would cut at offset 0 instead of 47, and a design that skips bytes after a test would not show length-1 chunks. Injected 48-byte patterns that match the marker are placed both inside and outside the minimum span, and long gaps force maximum cuts, which catches off-by-one errors in the comparisons. A second stream after an end-of-stream byte must restart its offsets at 0. Random backpressure checks that records are never dropped or changed while stalled.

// File: rtl/chunk_cutter_pkg.sv
`timescale 1ns/1ps
// Shared types and GF(2) helpers for the chunk boundary detector.
// Assumes a fixed fingerprint degree of 64, with the generator given by its low 64 coefficients.
package chunk_cutter_pkg;

    localparam int FP_W = 64;
    typedef logic [FP_W-1:0] fp_t;
    typedef logic [7:0]      byte_t;

    // Multiply a residue by x modulo x^FP_W + low.
    function automatic fp_t gf_mulx(input fp_t r, input fp_t low);
        return r[FP_W-1] ? ((r << 1) ^ low) : (r << 1);
    endfunction

    // Residue of v(x) * x^sh modulo x^FP_W + low, used at elaboration only.
    function automatic fp_t gf_mul_xpow(input byte_t v, input int sh, input fp_t low);
        fp_t r;
        r = '0;
        for (int b = 7; b >= 0; b--) begin
            r = gf_mulx(r, low) ^ {{(FP_W-1){1'b0}}, v[b]};
        end
        for (int s = 0; s < sh; s++) begin
            r = gf_mulx(r, low);
        end
        return r;
    endfunction

endpackage

// File: rtl/chunk_gf_table.sv
`timescale 1ns/1ps
// Lookup table of byte * x^SHIFT modulo the generator.
// Assumes SHIFT and POLY_LOW are elaboration constants; the contents are computed, not listed.
module chunk_gf_table
    import chunk_cutter_pkg::*;
#(
    parameter int  SHIFT    = 64,
    parameter fp_t POLY_LOW = 64'h1B
) (
    input  byte_t idx,
    output fp_t   val
);
    localparam int ENTRIES = 1 << 8;

    fp_t rom [ENTRIES];

    // One constant residue per possible byte value.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam fp_t ENTRY = gf_mul_xpow(8'(g), SHIFT, POLY_LOW);
        assign rom[g] = ENTRY;
    end

    // Combinational read.
    assign val = rom[idx];

endmodule

// File: rtl/chunk_fp_roll.sv
`timescale 1ns/1ps
// Rolling window fingerprint: keeps the last WIN_BYTES bytes and their residue.
// Each step folds in the new byte, folds back the top byte, and cancels the byte that leaves.
// Assumes step and restart are qualified by the caller; restart clears window, residue and fill.
module chunk_fp_roll
    import chunk_cutter_pkg::*;
#(
    parameter int  WIN_BYTES = 48,
    parameter fp_t POLY_LOW  = 64'h1B,
    parameter int  MARK_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              restart,
    input  byte_t             din,
    output logic [MARK_W-1:0] fp_low,
    output logic              full_next
);
    localparam int FILL_W    = $clog2(WIN_BYTES + 1);
    localparam int DROP_SH   = 8 * WIN_BYTES;
    localparam int KEEP_BITS = FP_W - 8;

    byte_t             win_q [WIN_BYTES];
    fp_t               fp_q;
    fp_t               fp_next;
    fp_t               fold_term;
    fp_t               drop_term;
    logic [FILL_W-1:0] fill_q;

    chunk_gf_table #(.SHIFT(FP_W), .POLY_LOW(POLY_LOW)) u_fold (
        .idx (fp_q[FP_W-1 -: 8]),
        .val (fold_term)
    );

    chunk_gf_table #(.SHIFT(DROP_SH), .POLY_LOW(POLY_LOW)) u_drop (
        .idx (win_q[WIN_BYTES-1]),
        .val (drop_term)
    );

    // Next residue: shift by one byte, add the new byte, reduce, and remove the departing byte.
    assign fp_next   = {fp_q[KEEP_BITS-1:0], din} ^ fold_term ^ drop_term;
    assign fp_low    = fp_next[MARK_W-1:0];
    assign full_next = (fill_q >= FILL_W'(WIN_BYTES - 1));

    // Window, residue and fill count update.
    always_ff @(posedge clk) begin
        if (!rst_n || (step && restart)) begin
            fp_q   <= '0;
            fill_q <= '0;
            for (int i = 0; i < WIN_BYTES; i++) begin
                win_q[i] <= '0;
            end
        end else if (step) begin
            fp_q     <= fp_next;
            win_q[0] <= din;
            for (int i = 1; i < WIN_BYTES; i++) begin
                win_q[i] <= win_q[i-1];
            end
            if (fill_q != FILL_W'(WIN_BYTES)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/chunk_len_ctrl.sv
`timescale 1ns/1ps
// Cut decision with offset and chunk length counters.
// Assumes configuration is stable during a stream; a max length of 0 disables the forced cut.
module chunk_len_ctrl #(
    parameter int LEN_W  = 32,
    parameter int OFF_W  = 32,
    parameter int MARK_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              last,
    input  logic              full_next,
    input  logic [MARK_W-1:0] fp_low,
    input  logic [MARK_W-1:0] cfg_marker,
    input  logic [LEN_W-1:0]  cfg_min_len,
    input  logic [LEN_W-1:0]  cfg_max_len,
    output logic              cut,
    output logic [OFF_W-1:0]  cut_off,
    output logic [LEN_W-1:0]  cut_len
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_next;
    logic [OFF_W-1:0] off_q;
    logic             marker_hit;
    logic             forced;

    // Decide whether the byte being accepted ends the chunk.
    always_comb begin
        len_next   = len_q + 1'b1;
        marker_hit = full_next && (fp_low == cfg_marker) && (len_next > cfg_min_len);
        forced     = (cfg_max_len != '0) && (len_next >= cfg_max_len);
        cut        = last || forced || marker_hit;
        cut_off    = off_q;
        cut_len    = len_next;
    end

    // Advance the counters on every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            off_q <= '0;
        end else if (step) begin
            len_q <= cut ? '0 : len_next;
            off_q <= last ? '0 : off_q + 1'b1;
        end
    end

endmodule

// File: rtl/chunk_cutter.sv
`timescale 1ns/1ps
// Content-defined chunk boundary detector (top).
// Accepts one byte per cycle. A pending boundary record that is not taken stalls input.
// Assumes cfg_* stay stable while a stream is in flight.
module chunk_cutter
    import chunk_cutter_pkg::*;
#(
    parameter int  WIN_BYTES = 48,
    parameter fp_t POLY_LOW  = 64'h1B,
    parameter int  MARK_W    = 13,
    parameter int  LEN_W     = 32,
    parameter int  OFF_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MARK_W-1:0] cfg_marker,
    input  logic [LEN_W-1:0]  cfg_min_len,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              bnd_valid,
    input  logic              bnd_ready,
    output logic [OFF_W-1:0]  bnd_offset,
    output logic [LEN_W-1:0]  bnd_len
);
    logic              step;
    logic              full_next;
    logic [MARK_W-1:0] fp_low;
    logic              cut;
    logic [OFF_W-1:0]  cut_off;
    logic [LEN_W-1:0]  cut_len;

    // Accept input whenever the output slot is free or being emptied.
    assign in_ready = !bnd_valid || bnd_ready;
    assign step     = in_valid && in_ready;

    chunk_fp_roll #(
        .WIN_BYTES (WIN_BYTES),
        .POLY_LOW  (POLY_LOW),
        .MARK_W    (MARK_W)
    ) u_roll (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .restart   (in_last),
        .din       (in_data),
        .fp_low    (fp_low),
        .full_next (full_next)
    );

    chunk_len_ctrl #(
        .LEN_W  (LEN_W),
        .OFF_W  (OFF_W),
        .MARK_W (MARK_W)
    ) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .last        (in_last),
        .full_next   (full_next),
        .fp_low      (fp_low),
        .cfg_marker  (cfg_marker),
        .cfg_min_len (cfg_min_len),
        .cfg_max_len (cfg_max_len),
        .cut         (cut),
        .cut_off     (cut_off),
        .cut_len     (cut_len)
    );

    // Boundary output register: load on a cut, clear when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd_valid  <= 1'b0;
            bnd_offset <= '0;
            bnd_len    <= '0;
        end else if (step && cut) begin
            bnd_valid  <= 1'b1;
            bnd_offset <= cut_off;
            bnd_len    <= cut_len;
        end else if (bnd_ready) begin
            bnd_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/chunk_cutter_chk.sv
`timescale 1ns/1ps
// Protocol and bound checks for the chunk boundary detector, bound to the top module.
module chunk_cutter_chk #(
    parameter int LEN_W = 32,
    parameter int OFF_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] cfg_max_len,
    input logic             in_ready,
    input logic             bnd_valid,
    input logic             bnd_ready,
    input logic [OFF_W-1:0] bnd_offset,
    input logic [LEN_W-1:0] bnd_len
);
    // R9
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !bnd_valid);

    // R8
    stall_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && !bnd_ready) |-> !in_ready);

    // R8
    hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && !bnd_ready) |=> (bnd_valid && $stable(bnd_offset) && $stable(bnd_len)));

    // R2
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_valid |-> (bnd_len != '0));

    // R2
    off_covers_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_valid |-> ((64'(bnd_offset) + 64'd1) >= 64'(bnd_len)));

    // R5
    max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && cfg_max_len != '0) |-> (bnd_len <= cfg_max_len));

endmodule

bind chunk_cutter chunk_cutter_chk #(.LEN_W(LEN_W), .OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_max_len (cfg_max_len),
    .in_ready    (in_ready),
    .bnd_valid   (bnd_valid),
    .bnd_ready   (bnd_ready),
    .bnd_offset  (bnd_offset),
    .bnd_len     (bnd_len)
);

// File: tb/tb_chunk_cutter.sv
`timescale 1ns/1ps
// Self-checking bench: a direct long-division model predicts every boundary.
module tb_chunk_cutter;
    localparam int          WIN  = 48;
    localparam logic [63:0] POLY = 64'h1B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cfg_marker = '0;
    logic [31:0] cfg_min_len = '0;
    logic [31:0] cfg_max_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        bnd_valid;
    logic        bnd_ready = 1'b0;
    logic [31:0] bnd_offset;
    logic [31:0] bnd_len;

    chunk_cutter dut (
        .clk(clk), .rst_n(rst_n), .cfg_marker(cfg_marker), .cfg_min_len(cfg_min_len),
        .cfg_max_len(cfg_max_len), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .bnd_valid(bnd_valid),
        .bnd_ready(bnd_ready), .bnd_offset(bnd_offset), .bnd_len(bnd_len)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] sbuf [0:1023];
    logic [7:0] pat  [48];
    logic [7:0] hist [48];
    longint mfill, mlen, moff;
    longint exp_off [0:1023];
    longint exp_len [0:1023];
    longint got_off [0:1023];
    longint got_len [0:1023];
    int ne, ng, stall_bad, hold_bad;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Remainder of a 48-byte window, oldest byte first, MSB first.
    function automatic logic [63:0] rem48(input logic [7:0] w [48]);
        logic [63:0] r = '0;
        for (int i = 0; i < WIN; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic c = r[63];
                r = (r << 1) | 64'(w[i][b]);
                if (c) r = r ^ POLY;
            end
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < WIN; i++) hist[i] = '0;
        mfill = 0; mlen = 0; moff = 0;
    endtask

    task automatic model_step(input logic [7:0] b, input bit last);
        logic [63:0] r;
        bit cut;
        for (int i = 0; i < WIN-1; i++) hist[i] = hist[i+1];
        hist[WIN-1] = b;
        if (mfill < WIN) mfill++;
        mlen++;
        r = rem48(hist);
        cut = last || (cfg_max_len != 0 && mlen >= cfg_max_len) ||
              (mfill == WIN && mlen > cfg_min_len && r[12:0] == cfg_marker);
        if (cut) begin
            exp_off[ne] = moff; exp_len[ne] = mlen; ne++;
            mlen = 0;
        end
        moff++;
        if (last) model_reset();
    endtask

    task automatic run_stream(input int n, input bit bp);
        int idx = 0;
        int drain = 0;
        bit clear_v = 0;
        bit prev_hold = 0;
        longint prev_off = 0, prev_len = 0;
        while (idx < n || drain < 10) begin
            @(negedge clk);
            if (clear_v) begin in_valid = 0; clear_v = 0; end
            bnd_ready = bp ? 1'($urandom % 2) : 1'b1;
            if (!in_valid) begin
                if (idx < n) begin
                    if (!bp || ($urandom % 4) != 0) begin
                        in_valid = 1; in_data = sbuf[idx]; in_last = (idx == n-1);
                    end
                end else drain++;
            end
            #1;
            if (prev_hold && !(bnd_valid && bnd_offset == 32'(prev_off) && bnd_len == 32'(prev_len)))
                hold_bad++;
            if (bnd_valid && !bnd_ready && in_ready) stall_bad++;
            prev_hold = bnd_valid && !bnd_ready;
            prev_off = bnd_offset; prev_len = bnd_len;
            if (bnd_valid && bnd_ready) begin
                got_off[ng] = bnd_offset; got_len[ng] = bnd_len; ng++;
            end
            if (in_valid && in_ready) begin
                model_step(in_data, in_last);
                idx++; clear_v = 1;
            end
        end
        @(negedge clk);
        in_valid = 0; in_last = 0;
    endtask

    task automatic clear_lists();
        ne = 0; ng = 0; stall_bad = 0; hold_bad = 0;
    endtask

    task automatic compare(input string req);
        int m;
        chk(ng == ne, "R2", {req, " boundary count"}, ng, ne);
        m = (ng < ne) ? ng : ne;
        for (int i = 0; i < m; i++) begin
            chk(got_off[i] == exp_off[i], req, "boundary offset", got_off[i], exp_off[i]);
            chk(got_len[i] == exp_len[i], req, "boundary length", got_len[i], exp_len[i]);
        end
        chk(stall_bad == 0, "R8", "input accepted while record stalled", stall_bad, 0);
        chk(hold_bad == 0, "R8", "stalled record changed", hold_bad, 0);
    endtask

    function automatic bit has_off(input longint o, input int from);
        for (int i = from; i < ng; i++) if (got_off[i] == o) return 1;
        return 0;
    endfunction

    task automatic put_pat(input int at);
        for (int i = 0; i < WIN; i++) sbuf[at+i] = pat[i];
    endtask

    task automatic fill_rand(input int n);
        for (int i = 0; i < n; i++) sbuf[i] = 8'($urandom);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(7));
        model_reset();
        for (int i = 0; i < WIN; i++) pat[i] = 8'($urandom);

        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        chk(bnd_valid == 0, "R9", "bnd_valid in reset", bnd_valid, 0);
        @(negedge clk); rst_n = 1; #1;
        chk(bnd_valid == 0, "R9", "bnd_valid after reset", bnd_valid, 0);
        chk(in_ready == 1, "R9", "in_ready after reset", in_ready, 1);

        // R3, R10: zero stream with marker 0, no bounds
        clear_lists();
        cfg_marker = 0; cfg_min_len = 0; cfg_max_len = 0;
        for (int i = 0; i < 60; i++) sbuf[i] = 0;
        run_stream(60, 0);
        compare("R3");
        chk(got_off[0] == 47, "R3", "first cut offset after fill", got_off[0], 47);
        chk(got_len[0] == 48, "R3", "first cut length after fill", got_len[0], 48);
        chk(got_len[1] == 1 && got_off[1] == 48, "R10", "next byte cut length", got_len[1], 1);
        chk(ng == 13, "R6", "cuts in zero stream", ng, 13);

        // R1, R6: random data with injected matching windows, pure marker mode
        clear_lists();
        cfg_marker = rem48(pat)[12:0];
        fill_rand(700);
        put_pat(100); put_pat(252); put_pat(500);
        run_stream(700, 0);
        compare("R1");
        chk(has_off(147, 0), "R1", "cut at injected window end 147", has_off(147, 0), 1);
        chk(has_off(299, 0), "R6", "cut at injected window end 299", has_off(299, 0), 1);
        chk(has_off(547, 0), "R6", "cut at injected window end 547", has_off(547, 0), 1);
        chk(has_off(699, 0), "R7", "end of stream cut", has_off(699, 0), 1);

        // R4, R5: min 120, max 250, with backpressure
        clear_lists();
        cfg_min_len = 120; cfg_max_len = 250;
        fill_rand(900);
        put_pat(60); put_pat(400); put_pat(700);
        run_stream(900, 1);
        compare("R4");
        chk(!has_off(107, 0), "R4", "match inside min span suppressed", has_off(107, 0), 0);
        chk(got_len[0] == 250 && got_off[0] == 249, "R5", "forced cut length", got_len[0], 250);

        // R5: small max on zero data before the window fills
        clear_lists();
        cfg_marker = 0; cfg_min_len = 3; cfg_max_len = 7;
        for (int i = 0; i < 40; i++) sbuf[i] = 0;
        run_stream(40, 1);
        compare("R5");
        chk(ng == 6, "R5", "forced cut count", ng, 6);
        chk(got_off[5] == 39 && got_len[5] == 5, "R7", "final partial chunk length", got_len[5], 5);

        // R7: restart, second stream offsets from 0 and fill counted again
        clear_lists();
        cfg_marker = rem48(pat)[12:0]; cfg_min_len = 0; cfg_max_len = 0;
        fill_rand(100);
        run_stream(100, 0);
        base = ng;
        fill_rand(80);
        put_pat(0);
        run_stream(80, 1);
        compare("R7");
        chk(has_off(47, base), "R7", "restarted stream cut at offset 47", has_off(47, base), 1);
        chk(got_off[ng-1] == 79, "R7", "restarted stream final offset", got_off[ng-1], 79);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule